// File: doc/BRIEF.md
# Timekeeper Update Handshake

This block manages the once-per-second handoff between the free-running time counters of a parallel-bus timekeeper and the copy of those counters that a host reads. When the counters ask for an update, the block raises a warning flag. It then waits one period of a 4,096 Hz rate, counted as a fixed number of 32,768 Hz oscillator enables. After that wait it fires a one-cycle strobe that copies the live counters into the host-visible registers. A host that reads the warning flag as low therefore knows the visible time will not change for at least that long.

The host sees two byte registers through a plain read/write port. The control register has a freeze bit and an interrupt enable. While the freeze bit is set, the copy strobe is withheld, so the visible time stays fixed while it is programmed or read. The counters keep running during this time. Update cycles missed while frozen are not made up afterwards. The status register shows the warning flag and an update-ended flag. The update-ended flag is set at the end of every update cycle and is cleared by reading the status register. The interrupt output is this flag gated by the enable.

Top module: `rtc_update_sync`

## Requirements
- R1: After reset, `uip`, `copy_stb` and `irq` are 0, the control register reads 0x00 and the status register reads 0x00.
- R2: With `uip` low, an `upd_req` sampled high at a clock edge drives `uip` high from that edge on.
- R3: `uip` stays high until the DIV-th `osc_tick` sampled while `uip` is high (default 8 ticks). At that edge `uip` falls, and `copy_stb` is high for exactly the one cycle that follows. `copy_stb` is never high at any other time.
- R4: An `upd_req` that arrives while `uip` is high is ignored. It does not restart or extend the wait, and it produces no second update.
- R5: Control register (address 0) bit 0 is SET. If SET is 1 at the edge where the wait ends, no `copy_stb` pulse occurs, but `uip` still rises and falls as usual.
- R6: When SET is cleared, no `copy_stb` pulse is produced for the cycles skipped while it was set. The next update cycle after the clear copies normally.
- R7: Status register (address 1) bit 0 reads `uip`. Bit 1 (UF) becomes 1 at the edge where each wait ends, whatever the state of the enable or SET.
- R8: A read of the status register (`reg_rd` high with address 1) clears UF at that edge. The value returned is the one before the clear. If an update ends at the same edge, UF stays 1.
- R9: Control bit 1 is the interrupt enable (UFE). `irq` is high exactly when UF and UFE are both 1, and it follows a change of UFE without waiting for a new update.
- R10: A write to the control register stores bits 1:0. All other bits of either register read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle enable at the 32,768 Hz rate |
| upd_req | input | 1 | Once-per-second update request from the counters |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (reading status clears UF) |
| reg_addr | input | 1 | 0 = control, 1 = status |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr`, combinational |
| uip | output | 1 | Update-in-progress warning |
| copy_stb | output | 1 | One-cycle copy strobe to the host-visible registers |
| irq | output | 1 | Update-ended interrupt |

## Verification
The hardest case to reach from the ports is a status read that lands on the very edge where an update ends. The bench follows every oscillator tick it drives inside the `uip` window. When it sees the tick that completes the wait, it raises the read strobe for that same edge. It then expects the returned value to show UF clear and a later read to show UF set. Freeze behaviour is covered by opening an update cycle while SET is held and dropping SET partway through or after it. The bench then confirms that no strobe appears until a fresh update request arrives.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;
  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_STAT = 1;
  localparam int unsigned CTRL_SET_BIT = 0;
  localparam int unsigned CTRL_UFE_BIT = 1;
  localparam int unsigned STAT_UIP_BIT = 0;
  localparam int unsigned STAT_UF_BIT  = 1;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_WAIT = 1'b1
  } upd_phase_t;
endpackage

// File: rtl/rtc_upd_timer.sv
module rtc_upd_timer #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic upd_req,
  output logic uip,
  output logic end_now
);
  import rtc_upd_pkg::*;
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  upd_phase_t phase_q;
  logic [CW-1:0] cnt_q;

  assign uip     = (phase_q == PH_WAIT);
  assign end_now = uip && osc_tick && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (upd_req) begin
          phase_q <= PH_WAIT;
          cnt_q   <= '0;
        end
        PH_WAIT: if (osc_tick) begin
          if (cnt_q == LAST) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R2: a request seen while idle opens the warning window
  a_r2_uip_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (!uip && upd_req) |=> uip);
  // R4: a pending window is never cut short or reopened by requests
  a_r4_window_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (uip && !end_now) |=> uip);
  // R3: the window closes right after its last tick
  a_r3_window_closes: assert property (@(posedge clk) disable iff (!rst_n)
    end_now |=> !uip);
endmodule

// File: rtl/rtc_upd_ctrl.sv
module rtc_upd_ctrl #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic          set_bit,
  output logic          ufe_bit
);
  import rtc_upd_pkg::*;

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_bit <= 1'b0;
      ufe_bit <= 1'b0;
    end else if (wr_en) begin
      set_bit <= wdata[CTRL_SET_BIT];
      ufe_bit <= wdata[CTRL_UFE_BIT];
    end
  end

  // R10: control bits only change through a write
  a_r10_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(set_bit) && $stable(ufe_bit)));
endmodule

// File: rtl/rtc_upd_flag.sv
module rtc_upd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic rd_clr,
  input  logic ufe,
  output logic uf,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      uf <= 1'b0;
    else if (set_ev) uf <= 1'b1;
    else if (rd_clr) uf <= 1'b0;
  end

  assign irq = uf & ufe;

  // R8: a status read with no coincident update leaves UF clear
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !set_ev) |=> !uf);
  // R8: a coincident update wins over the clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> uf);
endmodule

// File: rtl/rtc_update_sync.sv
module rtc_update_sync #(
  parameter int unsigned DW  = 8,
  parameter int unsigned DIV = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          osc_tick,
  input  logic          upd_req,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          uip,
  output logic          copy_stb,
  output logic          irq
);
  import rtc_upd_pkg::*;

  logic end_now, set_bit, ufe_bit, uf, copy_q;
  logic ctrl_wr, stat_rd;

  assign ctrl_wr = reg_wr && (reg_addr == 1'(ADDR_CTRL));
  assign stat_rd = reg_rd && (reg_addr == 1'(ADDR_STAT));

  rtc_upd_timer #(.DIV(DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .upd_req(upd_req),
    .uip(uip), .end_now(end_now)
  );

  rtc_upd_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .wdata(reg_wdata),
    .set_bit(set_bit), .ufe_bit(ufe_bit)
  );

  rtc_upd_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_ev(end_now), .rd_clr(stat_rd),
    .ufe(ufe_bit), .uf(uf), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) copy_q <= 1'b0;
    else        copy_q <= end_now && !set_bit;
  end
  assign copy_stb = copy_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == 1'(ADDR_CTRL)) begin
      reg_rdata[CTRL_SET_BIT] = set_bit;
      reg_rdata[CTRL_UFE_BIT] = ufe_bit;
    end else begin
      reg_rdata[STAT_UIP_BIT] = uip;
      reg_rdata[STAT_UF_BIT]  = uf;
    end
  end

  // R5: a copy never follows an edge at which SET was held
  a_r5_copy_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    copy_stb |-> !$past(set_bit));
  // R3: a copy only follows the close of the warning window
  a_r3_copy_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    copy_stb |-> ($past(uip) && !uip));
  // R7: the update-ended flag is up when the window has just closed
  a_r7_uf_on_close: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uip) |-> uf);
  // R9: no interrupt without the enable
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !ufe_bit |-> !irq);
endmodule

// File: tb/rtc_update_sync_test.sv
module rtc_update_sync_test;
  localparam int DW = 8;
  localparam int DIV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0;
  logic upd_req = 1'b0;
  logic reg_wr = 1'b0;
  logic reg_rd = 1'b0;
  logic reg_addr = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic uip, copy_stb, irq;

  int n_checks = 0;
  int n_fail = 0;
  int osc_gap = 3;
  int osc_cnt = 0;
  int mon_ticks = 0;
  bit prev_uip = 1'b0;
  bit exp_q[$];
  int cycles = 0;

  rtc_update_sync #(.DW(DW), .DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .upd_req(upd_req),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .uip(uip), .copy_stb(copy_stb), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // oscillator enable generator: one tick every osc_gap cycles
  always @(posedge clk) begin
    #2;
    if (osc_cnt + 1 >= osc_gap) begin
      osc_cnt = 0;
      osc_tick <= 1'b1;
    end else begin
      osc_cnt = osc_cnt + 1;
      osc_tick <= 1'b0;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (uip && !prev_uip) mon_ticks = 0;
      if (!uip && prev_uip) begin
        chk(mon_ticks == DIV, "R3 ticks in window", mon_ticks, DIV);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected update", 1, 0);
        end else begin
          bit e;
          e = exp_q.pop_front();
          chk(copy_stb == e, "R3/R5 copy strobe at window end", copy_stb, e);
        end
      end else if (copy_stb) begin
        chk(1'b0, "R6 stray copy strobe", 1, 0);
      end
      if (uip && osc_tick) mon_ticks = mon_ticks + 1;
      prev_uip = uip;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      chk(1'b0, "watchdog", cycles, 100000);
      finish_run();
    end
  end

  task automatic wr_reg(input logic a, input logic [DW-1:0] d);
    @(posedge clk); #2;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #2;
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic a, output logic [DW-1:0] d);
    @(posedge clk); #2;
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    d = reg_rdata;
    @(posedge clk); #2;
    reg_rd = 1'b0;
  endtask

  task automatic pulse_req(input bit exp_copy, input bit check_rise);
    @(posedge clk); #2;
    upd_req = 1'b1;
    if (check_rise) exp_q.push_back(exp_copy);
    @(negedge clk);
    @(posedge clk); #2;
    upd_req = 1'b0;
    if (check_rise) chk(uip == 1'b1, "R2 uip rises after request", uip, 1);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (uip) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    chk(uip == 0 && copy_stb == 0 && irq == 0, "R1 outputs in reset",
        {uip, copy_stb, irq}, 0);
    @(posedge clk); #2 rst_n = 1'b1;
    rd_reg(1'b0, d); chk(d == 8'h00, "R1 control after reset", d, 0);
    rd_reg(1'b1, d); chk(d == 8'h00, "R1 status after reset", d, 0);

    // basic update, gap 3
    pulse_req(1'b1, 1'b1);
    rd_reg(1'b1, d); chk(d[0] == 1'b1, "R7 status shows uip", d, 1);
    wait_idle();
    chk(irq == 1'b0, "R9 no irq when disabled", irq, 0);
    rd_reg(1'b1, d); chk(d == 8'h02, "R7 UF set with enable off", d, 2);
    rd_reg(1'b1, d); chk(d == 8'h00, "R8 read cleared UF", d, 0);

    // ticks every cycle, then sparse ticks
    osc_gap = 1;
    pulse_req(1'b1, 1'b1); wait_idle();
    osc_gap = 5;
    pulse_req(1'b1, 1'b1);
    // R4: second request inside the window
    repeat (6) @(posedge clk);
    pulse_req(1'b1, 1'b0);
    wait_idle();
    chk(exp_q.size() == 0, "R4 single update for two requests", exp_q.size(), 0);
    rd_reg(1'b1, d);

    // R10 control register
    wr_reg(1'b0, 8'hFF);
    rd_reg(1'b0, d); chk(d == 8'h03, "R10 control readback", d, 3);
    wr_reg(1'b0, 8'h02);
    rd_reg(1'b0, d); chk(d == 8'h02, "R10 control readback ufe only", d, 2);

    // R9 irq with enable
    osc_gap = 2;
    pulse_req(1'b1, 1'b1); wait_idle();
    chk(irq == 1'b1, "R9 irq raised", irq, 1);
    wr_reg(1'b0, 8'h00);
    @(negedge clk); chk(irq == 1'b0, "R9 irq follows enable off", irq, 0);
    wr_reg(1'b0, 8'h02);
    @(negedge clk); chk(irq == 1'b1, "R9 irq follows enable on", irq, 1);
    rd_reg(1'b1, d);
    @(negedge clk); chk(irq == 1'b0, "R8 read drops irq", irq, 0);

    // R5 freeze
    wr_reg(1'b0, 8'h01);
    pulse_req(1'b0, 1'b1); wait_idle();
    rd_reg(1'b1, d); chk(d == 8'h02, "R7 UF set while frozen", d, 2);
    pulse_req(1'b0, 1'b1);
    repeat (4) @(posedge clk);
    // R6 release partway: the window still ends with a copy
    exp_q[0] = 1'b1;
    wr_reg(1'b0, 8'h00);
    wait_idle();
    // R6 release after a missed cycle: nothing replays
    wr_reg(1'b0, 8'h01);
    pulse_req(1'b0, 1'b1); wait_idle();
    wr_reg(1'b0, 8'h00);
    repeat (30) @(negedge clk);
    chk(copy_stb == 1'b0 && exp_q.size() == 0, "R6 no replay after clear",
        copy_stb, 0);
    pulse_req(1'b1, 1'b1); wait_idle();
    rd_reg(1'b1, d);

    // R8 coincident read and update end
    osc_gap = 3;
    pulse_req(1'b1, 1'b1);
    forever begin
      @(negedge clk); #1;
      if (uip && osc_tick && mon_ticks == DIV) break;
    end
    reg_addr = 1'b1; reg_rd = 1'b1;
    #1 d = reg_rdata;
    chk(d[1] == 1'b0, "R8 read before set returns old UF", d, 0);
    @(posedge clk); #2 reg_rd = 1'b0;
    wait_idle();
    rd_reg(1'b1, d); chk(d == 8'h02, "R8 set wins over coincident clear", d, 2);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all updates observed", exp_q.size(), 0);
    finish_run();
  end
endmodule